// File: doc/BRIEF.md
# Paged Register and Array Address Decoder

This block is the address-decode core of a serial-bus register hub. A target-side front end passes it bus events, one per clock: a fresh start, a repeated start, an address byte, a data byte to write, or a request to read a data byte. The block turns the current address into an access to one of two regions. The first is a small volatile register space holding identity bytes, a mode register and scratch registers. The second is a read-only 1024-byte array split into eight 128-byte pages.

A 4-bit mode register selects a page and chooses between 1-byte and 2-byte register addressing. In 1-byte mode the upper half of the address space is a window onto the selected page. While a non-zero page is selected in that mode, every volatile register except the mode register is hidden. In 2-byte mode the page travels in the address itself. An internal pointer advances after each data byte and wraps inside its 128-byte block.

Top module: `hub_page_decoder`

## Requirements
- R1: After reset the mode register is 0 (page 0, 1-byte addressing), the pointer is 0, `rdata_o` is 0x00 and `rvalid_o` is low.
- R2: The mode register sits at volatile address 0x0B. Write bits [2:0] set the page and bit 3 selects 2-byte addressing. Bits [7:4] are discarded on write and read back as 0.
- R3: Volatile addresses 0x00..0x04 are read-only identity bytes: device type high byte, device type low byte, revision, vendor bank, vendor ID. Other volatile addresses are scratch bytes that read back what was last written, and 0x00 after reset.
- R4: In 1-byte mode, an address with bit 7 set reads array index page*128 + addr[6:0]. An address with bit 7 clear reads the volatile space.
- R5: In 1-byte mode with a non-zero page, volatile reads of any address other than 0x0B return 0x00, and volatile writes to such addresses are ignored.
- R6: In 2-byte mode the first address byte after a start is the low byte and the second is the high byte. A low byte with bit 7 set reads array index high[2:0]*128 + low[6:0]. The page field has no effect, and volatile registers are never hidden.
- R7: A fresh start clears the pointer to 0x00 and restarts the address byte order. A repeated start keeps the pointer.
- R8: After each data byte read or written, pointer bits [6:0] increment and wrap from 127 to 0. The higher pointer bits do not change.
- R9: Writes that land in the array change nothing, but the pointer still advances.
- R10: A read request gives its byte on `rdata_o` one cycle later, with `rvalid_o` high for that cycle only.
- R11: `id_ok_o` is high when the vendor bank and vendor ID bytes each have an odd count of set bits, and the ID's low 7 bits are neither 0x00 nor 0x7F.
- R12: The array byte at index n is n[7:0] XOR (n[9:7] shifted left by 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Fresh start condition seen on the bus |
| rstart_i | input | 1 | Repeated start condition seen on the bus |
| addr_wr_i | input | 1 | An address byte is on addr_byte_i |
| addr_byte_i | input | 8 | Address byte |
| wr_i | input | 1 | Write one data byte at the pointer |
| wdata_i | input | 8 | Data byte to write |
| rd_i | input | 1 | Read one data byte at the pointer |
| rdata_o | output | 8 | Read byte, held until the next read |
| rvalid_o | output | 1 | rdata_o was updated this cycle |
| id_ok_o | output | 1 | Vendor bank and ID bytes are well formed |

## Verification
A behavioural model in the bench replays every bus event and checks each clock. The first pattern walks the identity bytes after reset, which shows the reset pointer and the auto-increment. Scratch write and read-back across start and repeated start tells pointer retention apart from pointer clearing. Array reads at page edges in both addressing widths separate page-pointer indexing from address-carried indexing, and show the wrap within a block. Reads and writes with a non-zero page, followed by a return to page 0, show that hiding blocks both directions and that the mode register stays reachable.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int PAGE_W  = 3;               // page number width
  localparam int OFS_W   = 7;               // offset within a page
  localparam int IDX_W   = PAGE_W + OFS_W;  // array index width
  localparam int N_ID    = 5;               // read-only identity bytes
  localparam logic [OFS_W-1:0] MODE_ADDR = 7'h0B;

  typedef struct packed {
    logic              wide;   // 2-byte addressing
    logic [PAGE_W-1:0] page;
  } mode_t;

  // Array content model
  function automatic logic [7:0] nvm_byte(input logic [IDX_W-1:0] n);
    logic [7:0] tag;
    tag = 8'(n[IDX_W-1:OFS_W]) << 4;
    return n[7:0] ^ tag;
  endfunction
endpackage

// File: rtl/hub_mode_reg.sv
module hub_mode_reg
  import hub_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output mode_t      mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i[$bits(mode_t)-1:0];
  end

  assign mode_o = mode_q;

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_q));
endmodule

// File: rtl/hub_addr_ptr.sv
module hub_addr_ptr
  import hub_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rstart_i,
  input  logic              addr_wr_i,
  input  logic [7:0]        addr_byte_i,
  input  logic              wide_i,
  input  logic              step_i,
  output logic [7:0]        lo_o,
  output logic [PAGE_W-1:0] hi_o
);
  logic [7:0]        lo_q;
  logic [PAGE_W-1:0] hi_q;
  logic              second_q;  // next address byte is the high byte

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0; hi_q <= '0; second_q <= 1'b0;
    end else if (start_i) begin
      lo_q <= '0; hi_q <= '0; second_q <= 1'b0;
    end else if (rstart_i) begin
      second_q <= 1'b0;
    end else if (addr_wr_i) begin
      if (wide_i && second_q) begin
        hi_q     <= addr_byte_i[PAGE_W-1:0];
        second_q <= 1'b0;
      end else begin
        lo_q     <= addr_byte_i;
        if (!wide_i) hi_q <= '0;
        second_q <= wide_i;
      end
    end else if (step_i) begin
      lo_q[OFS_W-1:0] <= lo_q[OFS_W-1:0] + 1'b1;  // wrap inside block
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  p_start_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (lo_q == '0) && (hi_q == '0));

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i && !rstart_i && !addr_wr_i && (&lo_q[OFS_W-1:0]))
      |=> (lo_q[OFS_W-1:0] == '0) && $stable(lo_q[7]) && $stable(hi_q));
endmodule

// File: rtl/hub_vol_regs.sv
module hub_vol_regs
  import hub_pkg::*;
#(
  parameter logic [15:0] DEV_TYPE = 16'hA3C1,
  parameter logic [7:0]  DEV_REV  = 8'h12,
  parameter logic [7:0]  VND_BANK = 8'h80,
  parameter logic [7:0]  VND_ID   = 8'h32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             id_ok_o
);
  localparam int DEPTH = 1 << OFS_W;

  logic [7:0] scr_q [DEPTH];
  logic       is_id;

  assign is_id = (32'(addr_i) < N_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) scr_q[i] <= '0;
    end else if (we_i && !is_id) begin
      scr_q[addr_i] <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      7'd0:    rdata_o = DEV_TYPE[15:8];
      7'd1:    rdata_o = DEV_TYPE[7:0];
      7'd2:    rdata_o = DEV_REV;
      7'd3:    rdata_o = VND_BANK;
      7'd4:    rdata_o = VND_ID;
      default: rdata_o = scr_q[addr_i];
    endcase
  end

  assign id_ok_o = (^VND_BANK) && (^VND_ID) &&
                   (VND_ID[6:0] != 7'h00) && (VND_ID[6:0] != 7'h7F);
endmodule

// File: rtl/hub_nvm_rom.sv
module hub_nvm_rom
  import hub_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       data_o
);
  assign data_o = nvm_byte(idx_i);
endmodule

// File: rtl/hub_page_decoder.sv
module hub_page_decoder
  import hub_pkg::*;
#(
  parameter logic [15:0] DEV_TYPE = 16'hA3C1,
  parameter logic [7:0]  DEV_REV  = 8'h12,
  parameter logic [7:0]  VND_BANK = 8'h80,
  parameter logic [7:0]  VND_ID   = 8'h32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rstart_i,
  input  logic       addr_wr_i,
  input  logic [7:0] addr_byte_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o,
  output logic       id_ok_o
);
  mode_t             mode;
  logic [7:0]        lo;
  logic [PAGE_W-1:0] hi;
  logic              step, rd_go, vol, is_mode, hide;
  logic              mode_we, vol_we;
  logic [IDX_W-1:0]  nvm_idx;
  logic [7:0]        nvm_data, vol_data, rd_val;
  logic [7:0]        rdata_q;
  logic              rvalid_q;

  // Bus event priority: start > rstart > address > data
  assign step    = (wr_i || rd_i) && !start_i && !rstart_i && !addr_wr_i;
  assign rd_go   = step && rd_i && !wr_i;
  assign vol     = !lo[7];
  assign is_mode = vol && (lo[OFS_W-1:0] == MODE_ADDR);
  assign hide    = vol && !is_mode && !mode.wide && (mode.page != '0);
  assign mode_we = step && wr_i && is_mode;
  assign vol_we  = step && wr_i && vol && !is_mode && !hide;
  assign nvm_idx = mode.wide ? {hi, lo[OFS_W-1:0]} : {mode.page, lo[OFS_W-1:0]};

  hub_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we),
    .wdata_i (wdata_i),
    .mode_o  (mode)
  );

  hub_addr_ptr u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .addr_wr_i   (addr_wr_i),
    .addr_byte_i (addr_byte_i),
    .wide_i      (mode.wide),
    .step_i      (step),
    .lo_o        (lo),
    .hi_o        (hi)
  );

  hub_vol_regs #(
    .DEV_TYPE (DEV_TYPE),
    .DEV_REV  (DEV_REV),
    .VND_BANK (VND_BANK),
    .VND_ID   (VND_ID)
  ) u_vol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vol_we),
    .addr_i  (lo[OFS_W-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (vol_data),
    .id_ok_o (id_ok_o)
  );

  hub_nvm_rom u_rom (
    .idx_i  (nvm_idx),
    .data_o (nvm_data)
  );

  always_comb begin
    if (!vol)         rd_val = nvm_data;
    else if (hide)    rd_val = 8'h00;
    else if (is_mode) rd_val = 8'(mode);
    else              rd_val = vol_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
      if (rd_go) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> rvalid_o);

  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> !rvalid_o && $stable(rdata_o));

  p_hidden_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && hide) |=> (rdata_o == 8'h00));

  p_mode_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && is_mode) |=> (rdata_o[7:4] == 4'h0));
endmodule

// File: tb/hub_page_decoder_test.sv
module hub_page_decoder_test;
  localparam logic [15:0] T_TYPE = 16'hA3C1;
  localparam logic [7:0]  T_REV  = 8'h12;
  localparam logic [7:0]  T_BANK = 8'h80;
  localparam logic [7:0]  T_VID  = 8'h32;

  localparam int K_START = 0, K_RSTART = 1, K_ADDR = 2, K_WR = 3, K_RD = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, rstart_i = 0, addr_wr_i = 0, wr_i = 0, rd_i = 0;
  logic [7:0] addr_byte_i = 0, wdata_i = 0;
  logic [7:0] rdata_o;
  logic rvalid_o, id_ok_o;

  always #10 clk_i = ~clk_i;

  hub_page_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rstart_i(rstart_i),
    .addr_wr_i(addr_wr_i), .addr_byte_i(addr_byte_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .id_ok_o(id_ok_o)
  );

  int n_run = 0, n_fail = 0;

  // Reference model state
  int m_mode = 0, m_lo = 0, m_hi = 0;
  bit m_second = 0;
  int m_scr [128];
  int e_rdata = 0;
  bit e_rvalid = 0;

  function automatic int arr_byte(int n);
    return (n % 256) ^ ((n / 128) * 16);
  endfunction

  function automatic bit m_hidden();
    return (m_mode / 8 == 0) && (m_mode % 8 != 0) && (m_lo % 128 != 11);
  endfunction

  function automatic int m_read();
    int a;
    a = m_lo % 128;
    if (m_lo >= 128) begin
      if (m_mode >= 8) return arr_byte(m_hi * 128 + a);
      return arr_byte((m_mode % 8) * 128 + a);
    end
    if (a == 11) return m_mode;
    if (m_hidden()) return 0;
    case (a)
      0: return int'(T_TYPE[15:8]);
      1: return int'(T_TYPE[7:0]);
      2: return int'(T_REV);
      3: return int'(T_BANK);
      4: return int'(T_VID);
      default: return m_scr[a];
    endcase
  endfunction

  function automatic void m_step();
    m_lo = (m_lo / 128) * 128 + ((m_lo % 128) + 1) % 128;
  endfunction

  task automatic check(string tag, bit ok, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one bus event at a falling edge, update model, compare next falling edge
  task automatic op(int kind, int b, string tag);
    e_rvalid = 0;
    case (kind)
      K_START:  begin start_i = 1; m_lo = 0; m_hi = 0; m_second = 0; end
      K_RSTART: begin rstart_i = 1; m_second = 0; end
      K_ADDR: begin
        addr_wr_i = 1; addr_byte_i = 8'(b);
        if (m_mode >= 8 && m_second) begin m_hi = b % 8; m_second = 0; end
        else begin
          m_lo = b;
          if (m_mode < 8) m_hi = 0;
          m_second = (m_mode >= 8);
        end
      end
      K_WR: begin
        wr_i = 1; wdata_i = 8'(b);
        if (m_lo < 128) begin
          if (m_lo % 128 == 11) m_mode = b % 16;
          else if (!m_hidden() && (m_lo % 128) >= 5) m_scr[m_lo % 128] = b;
        end
        m_step();
      end
      default: begin
        rd_i = 1; e_rdata = m_read(); e_rvalid = 1; m_step();
      end
    endcase
    @(negedge clk_i);
    start_i = 0; rstart_i = 0; addr_wr_i = 0; wr_i = 0; rd_i = 0;
    check({tag, " R10 rvalid"}, rvalid_o == e_rvalid, int'(rvalid_o), int'(e_rvalid));
    if (e_rvalid)
      check(tag, int'(rdata_o) == e_rdata, int'(rdata_o), e_rdata);
  endtask

  task automatic rd_at(int a, string tag);
    op(K_ADDR, a, tag);
    op(K_RD, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_scr[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 rdata", rdata_o == 8'h00, int'(rdata_o), 0);
    check("R1 rvalid", rvalid_o == 1'b0, int'(rvalid_o), 0);
    check("R11 id_ok", id_ok_o == 1'b1, int'(id_ok_o), 1);
    // R1/R3/R8: burst from reset pointer over identity bytes
    for (int i = 0; i < 6; i++) op(K_RD, 0, "R3 id burst");
    rd_at(11, "R1 mode reset");
    // R3/R7: scratch write then read back across starts
    op(K_ADDR, 8'h20, "R3 addr");
    op(K_WR, 8'hA5, "R3 wr");
    op(K_WR, 8'h5A, "R3 wr");
    op(K_START, 0, "R7 start");
    op(K_ADDR, 8'h20, "R7 addr");
    op(K_RSTART, 0, "R7 rstart");
    op(K_RD, 0, "R7 keep ptr");
    op(K_RD, 0, "R8 incr");
    op(K_START, 0, "R7 start");
    op(K_RD, 0, "R7 ptr cleared");
    // R3 identity write ignored
    op(K_ADDR, 8'h02, "R3 addr");
    op(K_WR, 8'hFF, "R3 ro wr");
    rd_at(2, "R3 ro rev");
    // R2: reserved bits dropped
    op(K_ADDR, 8'h0B, "R2 addr");
    op(K_WR, 8'hF2, "R2 wr");
    rd_at(11, "R2 mode rd");
    // R4/R12/R8 array window, page 2, wrap
    rd_at(8'h80, "R4 page2 first");
    rd_at(8'hFF, "R4 page2 last");
    op(K_RD, 0, "R8 wrap");
    // R5 hidden volatile space
    rd_at(8'h00, "R5 type hidden");
    rd_at(8'h04, "R5 vid hidden");
    op(K_ADDR, 8'h20, "R5 addr");
    op(K_WR, 8'h11, "R5 wr ignored");
    // R9 array writes ignored, pointer still moves
    op(K_ADDR, 8'h90, "R9 addr");
    op(K_WR, 8'h77, "R9 wr");
    op(K_RD, 0, "R9 ptr advanced");
    rd_at(8'h90, "R9 unchanged");
    // Page 7 last byte
    op(K_ADDR, 8'h0B, "R2 addr");
    op(K_WR, 8'h07, "R2 wr");
    rd_at(8'hFF, "R12 page7 last");
    // back to page 0: R5 write was dropped
    op(K_ADDR, 8'h0B, "R2 addr");
    op(K_WR, 8'h00, "R2 wr");
    rd_at(8'h20, "R5 scratch kept");
    // R6 2-byte mode, page field set but ignored
    op(K_ADDR, 8'h0B, "R6 addr");
    op(K_WR, 8'h0D, "R6 wr mode");
    op(K_START, 0, "R6 start");
    op(K_ADDR, 8'h85, "R6 lo");
    op(K_ADDR, 8'h05, "R6 hi");
    op(K_RD, 0, "R6 array");
    op(K_RD, 0, "R6 incr");
    op(K_START, 0, "R6 start");
    op(K_ADDR, 8'hFF, "R6 lo");
    op(K_ADDR, 8'h01, "R6 hi");
    op(K_RD, 0, "R6 blk end");
    op(K_RD, 0, "R8 wrap wide");
    op(K_START, 0, "R6 start");
    op(K_ADDR, 8'h20, "R6 lo");
    op(K_ADDR, 8'h00, "R6 hi");
    op(K_RD, 0, "R6 not hidden");
    op(K_RSTART, 0, "R7 rstart");
    op(K_ADDR, 8'h00, "R6 lo");
    op(K_ADDR, 8'h00, "R6 hi");
    op(K_RD, 0, "R6 type visible");
    op(K_START, 0, "R6 start");
    op(K_ADDR, 8'h0B, "R6 lo");
    op(K_ADDR, 8'h00, "R6 hi");
    op(K_RD, 0, "R2 mode wide");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule